// File: doc/BRIEF.md
# Binary-Field Montgomery Ladder Point Multiplier

This block computes the scalar multiple of a point on a non-supersingular binary elliptic curve y^2 + xy = x^3 + ax^2 + b over GF(2^191), using only x-coordinates in projective X/Z form. The caller presents the base-point x-coordinate, the curve constant b and the scalar, then pulses `start_i`. The block returns two projective pairs: (X1,Z1) holds the x-coordinate of kP and (X2,Z2) holds that of (k+1)P. A later stage converts these to affine form. That conversion and field inversion are not part of this block.

Each ladder step performs one projective point addition and one projective point doubling in the same three clock cycles. Two bit-parallel field multipliers, a set of squarers and XOR logic do the work. The four coordinates live in two small register banks, one per point pair. The scalar bit only decides which pair receives the addition and which receives the doubling. The square root of b that the doubling formula needs is derived once, when the operands are captured, from a closed form valid for an odd-degree trinomial.

Field elements are 191-bit vectors. Bit i is the coefficient of x^i, and the reduction polynomial is x^191 + x^9 + 1. Both the field width and the middle tap are parameters and must be odd. The interface has no back-pressure. `start_i` is a single-cycle request that is taken only while the block is idle. The results stay on the outputs until the next accepted request, so a consumer may read them at any later time.

Top module: `ecc_mont_ladder`

## Requirements
- R1: One clock edge after a request is accepted, the outputs show X1 = x, Z1 = 1, X2 = x^4 + b and Z2 = x^2, where x and b are the values present on `base_x_i` and `curve_b_i` at the accepting edge.
- R2: The most significant scalar bit is treated as 1 whatever its value. Bits NBITS-2 down to 0 are consumed in descending order.
- R3: For a scalar bit of 1, pair 1 receives the addition and pair 2 the doubling. For a bit of 0 the roles are swapped. Both operations always use the coordinate values from before the step.
- R4: Addition of pair a with pair d gives Za' = (Xa·Zd + Za·Xd)^2 and Xa' = x·Za' + (Xa·Zd)·(Za·Xd).
- R5: Doubling of pair d gives Zd' = Xd^2·Zd^2 and Xd' = Xd^4 + b·Zd^4. The internal square root c of b satisfies c^2 = b.
- R6: All field products and squares are reduced modulo x^191 + x^9 + 1, and field addition is bitwise XOR.
- R7: Each consumed scalar bit takes exactly three cycles. `done_o` is high in the cycle after the (3·(NBITS-1)+1)-th rising edge that follows the edge that accepted the request (571 edges for the default size).
- R8: `done_o` is high for exactly one cycle per accepted request.
- R9: Outside a run, the four coordinate outputs do not change from the done cycle until the next accepted request.
- R10: `start_i` is ignored from the accepting edge through the done cycle. Operands presented during that window do not affect the running result.
- R11: After reset all four coordinate outputs are zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle request, taken only when idle |
| base_x_i | input | M | Affine x-coordinate of the base point |
| curve_b_i | input | M | Curve constant b |
| scalar_i | input | NBITS | Scalar k; top bit assumed set |
| x1_o | output | M | Projective X of pair 1 (kP) |
| z1_o | output | M | Projective Z of pair 1 |
| x2_o | output | M | Projective X of pair 2 ((k+1)P) |
| z2_o | output | M | Projective Z of pair 2 |
| done_o | output | 1 | One-cycle pulse when the final step has been written |

## Verification
The addition of one pair and the doubling of the other always share a cycle, and both write to their own bank at the same clock edge. Whether each one read the other's old or new values therefore decides the result. All-ones scalars keep the roles fixed, and alternating scalars swap them at every bit. In both cases the final four coordinates are compared with a behavioural ladder that works with b directly rather than its square root. A request arriving in the done cycle, and another arriving in the middle of a run, test the overlap of capture with completion. These are judged cycle by cycle against the expected done timing and the held outputs.

// File: rtl/ecl_pkg.sv
package ecl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_STEP,
    ST_FIN
  } ladder_st_e;

  // Three slots of one ladder step: cross products, mixing, finishing writes
  typedef enum logic [1:0] {
    PH_CROSS,
    PH_MIX,
    PH_FINISH
  } ladder_ph_e;

  localparam int NUM_PAIRS = 2;
  localparam int SLOTS     = 2;
  localparam int SLOT_X    = 0;
  localparam int SLOT_Z    = 1;

endpackage

// File: rtl/gf2m_mul.sv
module gf2m_mul #(
  parameter int M   = 191,
  parameter int TAP = 9
) (
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic [M-1:0] p_o
);
  localparam int PW = 2*M - 1;

  logic [PW-1:0] acc;

  // Carry-free product followed by folding of the high half onto x^TAP + 1
  always_comb begin
    acc = '0;
    for (int i = 0; i < M; i++) begin
      if (b_i[i]) acc = acc ^ ({{(M-1){1'b0}}, a_i} << i);
    end
    for (int j = PW-1; j >= M; j--) begin
      if (acc[j]) begin
        acc[j]         = 1'b0;
        acc[j-M]       = ~acc[j-M];
        acc[j-M+TAP]   = ~acc[j-M+TAP];
      end
    end
    p_o = acc[M-1:0];
  end

endmodule

// File: rtl/gf2m_sqr.sv
module gf2m_sqr #(
  parameter int M   = 191,
  parameter int TAP = 9
) (
  input  logic [M-1:0] a_i,
  output logic [M-1:0] s_o
);
  localparam int PW = 2*M - 1;

  logic [PW-1:0] spread;

  // Squaring spreads bit i to position 2i, then the same fold as a product
  always_comb begin
    spread = '0;
    for (int i = 0; i < M; i++) spread[2*i] = a_i[i];
    for (int j = PW-1; j >= M; j--) begin
      if (spread[j]) begin
        spread[j]       = 1'b0;
        spread[j-M]     = ~spread[j-M];
        spread[j-M+TAP] = ~spread[j-M+TAP];
      end
    end
    s_o = spread[M-1:0];
  end

endmodule

// File: rtl/ladder_bank.sv
module ladder_bank #(
  parameter int W     = 191,
  parameter int DEPTH = 2,
  parameter int NP    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NP-1:0]             we_i,
  input  logic [NP-1:0][AW-1:0]     addr_i,
  input  logic [NP-1:0][W-1:0]      wdata_i,
  output logic [NP-1:0][W-1:0]      rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] word_view [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [W-1:0]  word_q;
    logic [NP-1:0] hit;

    always_comb begin
      for (int p = 0; p < NP; p++) hit[p] = we_i[p] && (addr_i[p] == AW'(w));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else begin
        for (int p = 0; p < NP; p++) begin
          if (hit[p]) word_q <= wdata_i[p];
        end
      end
    end

    assign word_view[w] = word_q;

    // R7
    single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit) <= 1);
  end

  always_comb begin
    for (int p = 0; p < NP; p++) rdata_o[p] = word_view[addr_i[p]];
  end

endmodule

// File: rtl/ladder_ctrl.sv
module ladder_ctrl
  import ecl_pkg::*;
#(
  parameter int NBITS = 191
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NBITS-1:0] scalar_i,
  output logic             cap_o,
  output logic             init_o,
  output logic             step_o,
  output ladder_ph_e       phase_o,
  output logic             bit_o,
  output logic             done_o
);
  localparam int IW = (NBITS > 2) ? $clog2(NBITS) : 1;
  localparam logic [IW-1:0] FIRST_IDX = IW'(NBITS - 2);

  ladder_st_e       state_q;
  ladder_ph_e       phase_q;
  logic [IW-1:0]    idx_q;
  logic [NBITS-1:0] k_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_CROSS;
      idx_q   <= '0;
      k_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            k_q     <= scalar_i;
            state_q <= ST_INIT;
          end
        end
        ST_INIT: begin
          state_q <= ST_STEP;
          phase_q <= PH_CROSS;
          idx_q   <= FIRST_IDX;
        end
        ST_STEP: begin
          case (phase_q)
            PH_CROSS: phase_q <= PH_MIX;
            PH_MIX:   phase_q <= PH_FINISH;
            default: begin
              phase_q <= PH_CROSS;
              if (idx_q == '0) state_q <= ST_FIN;
              else             idx_q   <= idx_q - IW'(1);
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cap_o   = (state_q == ST_IDLE) && start_i;
  assign init_o  = (state_q == ST_INIT);
  assign step_o  = (state_q == ST_STEP);
  assign phase_o = phase_q;
  assign bit_o   = k_q[idx_q];
  assign done_o  = (state_q == ST_FIN);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  phase_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && phase_o == PH_CROSS) |=> (step_o && phase_o == PH_MIX));

  // R7
  last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && phase_o == PH_FINISH && idx_q == '0) |=> done_o);

  // R10
  scalar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(k_q));

endmodule

// File: rtl/ecc_mont_ladder.sv
module ecc_mont_ladder
  import ecl_pkg::*;
#(
  parameter int M     = 191,
  parameter int TAP   = 9,
  parameter int NBITS = 191
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [M-1:0]     base_x_i,
  input  logic [M-1:0]     curve_b_i,
  input  logic [NBITS-1:0] scalar_i,
  output logic [M-1:0]     x1_o,
  output logic [M-1:0]     z1_o,
  output logic [M-1:0]     x2_o,
  output logic [M-1:0]     z2_o,
  output logic             done_o
);
  localparam int BAW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int HALF_HI = (M + 1) / 2;
  localparam int HALF_LO = (TAP + 1) / 2;
  localparam logic [M-1:0] ONE = M'(1);

  logic       cap, init_en, step_en, kbit;
  ladder_ph_e ph;

  ladder_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .scalar_i (scalar_i),
    .cap_o    (cap),
    .init_o   (init_en),
    .step_o   (step_en),
    .phase_o  (ph),
    .bit_o    (kbit),
    .done_o   (done_o)
  );

  // Square root of b: even coefficients plus odd ones times sqrt(x)
  logic [M-1:0] b_even, b_odd, b_root;
  always_comb begin
    b_even = '0;
    b_odd  = '0;
    for (int i = 0; i < HALF_HI; i++)     b_even[i] = curve_b_i[2*i];
    for (int i = 0; i < (M - 1) / 2; i++) b_odd[i]  = curve_b_i[2*i+1];
    b_root = b_even ^ (b_odd << HALF_HI) ^ (b_odd << HALF_LO);
  end

  // Captured operands and step temporaries
  logic [M-1:0] px_q, pb_q, pbc_q;
  logic [M-1:0] cross_a_q, cross_b_q, n_q, s_q;

  // Bank access
  logic [NUM_PAIRS-1:0][SLOTS-1:0]        bank_we;
  logic [NUM_PAIRS-1:0][SLOTS-1:0][M-1:0] bank_wd;
  logic [NUM_PAIRS-1:0][SLOTS-1:0][M-1:0] bank_rd;
  logic [SLOTS-1:0][BAW-1:0]              slot_addr;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) slot_addr[s] = BAW'(s);
  end

  // Pair roles: the doubled pair index equals the scalar bit
  logic         add_sel, dbl_sel;
  logic [M-1:0] xa, za, xd, zd;
  assign dbl_sel = kbit;
  assign add_sel = ~kbit;
  assign xa = bank_rd[add_sel][SLOT_X];
  assign za = bank_rd[add_sel][SLOT_Z];
  assign xd = bank_rd[dbl_sel][SLOT_X];
  assign zd = bank_rd[dbl_sel][SLOT_Z];

  // Two multipliers with phase-dependent operands
  logic [M-1:0] mul_a_x, mul_a_y, mul_a_p;
  logic [M-1:0] mul_b_x, mul_b_y, mul_b_p;
  logic [M-1:0] sq_in, sq_x, quart, sq_z, sq_sum, sq_bz;

  always_comb begin
    case (ph)
      PH_CROSS: begin
        mul_a_x = xa;     mul_a_y = zd;
        mul_b_x = za;     mul_b_y = xd;
      end
      PH_MIX: begin
        mul_a_x = cross_a_q; mul_a_y = cross_b_q;
        mul_b_x = sq_x;      mul_b_y = sq_z;
      end
      default: begin
        mul_a_x = px_q;   mul_a_y = za;
        mul_b_x = pbc_q;  mul_b_y = s_q;
      end
    endcase
  end

  gf2m_mul #(.M(M), .TAP(TAP)) u_mul_a (.a_i(mul_a_x), .b_i(mul_a_y), .p_o(mul_a_p));
  gf2m_mul #(.M(M), .TAP(TAP)) u_mul_b (.a_i(mul_b_x), .b_i(mul_b_y), .p_o(mul_b_p));

  assign sq_in = init_en ? px_q : xd;

  gf2m_sqr #(.M(M), .TAP(TAP)) u_sq_x   (.a_i(sq_in),                  .s_o(sq_x));
  gf2m_sqr #(.M(M), .TAP(TAP)) u_sq_4   (.a_i(sq_x),                   .s_o(quart));
  gf2m_sqr #(.M(M), .TAP(TAP)) u_sq_z   (.a_i(zd),                     .s_o(sq_z));
  gf2m_sqr #(.M(M), .TAP(TAP)) u_sq_sum (.a_i(cross_a_q ^ cross_b_q),  .s_o(sq_sum));
  gf2m_sqr #(.M(M), .TAP(TAP)) u_sq_bz  (.a_i(mul_b_p),                .s_o(sq_bz));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_q      <= '0;
      pb_q      <= '0;
      pbc_q     <= '0;
      cross_a_q <= '0;
      cross_b_q <= '0;
      n_q       <= '0;
      s_q       <= '0;
    end else begin
      if (cap) begin
        px_q  <= base_x_i;
        pb_q  <= curve_b_i;
        pbc_q <= b_root;
      end
      if (step_en && ph == PH_CROSS) begin
        cross_a_q <= mul_a_p;
        cross_b_q <= mul_b_p;
      end
      if (step_en && ph == PH_MIX) begin
        n_q <= mul_a_p;
        s_q <= sq_z;
      end
    end
  end

  // Per-pair bank write selection
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    logic is_add;
    assign is_add = (add_sel == 1'(g));

    assign bank_we[g][SLOT_X] = init_en | (step_en & (ph == PH_FINISH));
    assign bank_we[g][SLOT_Z] = init_en | (step_en & (ph == PH_MIX));

    assign bank_wd[g][SLOT_X] = init_en ? ((g == 0) ? px_q : (quart ^ pb_q))
                                        : (is_add ? (mul_a_p ^ n_q) : (quart ^ sq_bz));
    assign bank_wd[g][SLOT_Z] = init_en ? ((g == 0) ? ONE : sq_x)
                                        : (is_add ? sq_sum : mul_b_p);

    ladder_bank #(.W(M), .DEPTH(SLOTS), .NP(SLOTS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (bank_we[g]),
      .addr_i  (slot_addr),
      .wdata_i (bank_wd[g]),
      .rdata_o (bank_rd[g])
    );
  end

  assign x1_o = bank_rd[0][SLOT_X];
  assign z1_o = bank_rd[0][SLOT_Z];
  assign x2_o = bank_rd[1][SLOT_X];
  assign z2_o = bank_rd[1][SLOT_Z];

  // Checker-only squarer for the derived root
  logic [M-1:0] root_sq;
  gf2m_sqr #(.M(M), .TAP(TAP)) u_root_chk (.a_i(pbc_q), .s_o(root_sq));

  // R5
  root_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (root_sq == pb_q));

  // R1
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_en |=> (x1_o == px_q && z1_o == ONE));

  // R9
  coord_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_en && !step_en) |=> $stable({x1_o, z1_o, x2_o, z2_o}));

  // R7
  cross_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && ph == PH_CROSS) |=> $stable({x1_o, z1_o, x2_o, z2_o}));

endmodule

// File: tb/ecc_mont_ladder_tb_top.sv
module ecc_mont_ladder_tb_top;
  localparam int M   = 191;
  localparam int TAP = 9;
  localparam int NB  = 191;
  localparam int LAT = 3 * (NB - 1) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [M-1:0]  bx = '0, cb = '0;
  logic [NB-1:0] ks = '0;
  logic [M-1:0]  x1, z1, x2, z2;
  logic          done;

  ecc_mont_ladder #(.M(M), .TAP(TAP), .NBITS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .base_x_i(bx), .curve_b_i(cb), .scalar_i(ks),
    .x1_o(x1), .z1_o(z1), .x2_o(x2), .z2_o(z2), .done_o(done)
  );

  always #4 clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R3 R4 R5 R6";

  task automatic chk(input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Shift-and-add field product, reducing one bit at a time (R6)
  function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r = '0;
    logic         top;
    for (int i = M - 1; i >= 0; i--) begin
      top = r[M-1];
      r   = r << 1;
      if (top) r = r ^ M'(1) ^ (M'(1) << TAP);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] fsq(input logic [M-1:0] a);
    return fmul(a, a);
  endfunction

  function automatic void ref_ladder(input logic [M-1:0] x, input logic [M-1:0] b,
                                     input logic [NB-1:0] k,
                                     output logic [M-1:0] rx1, output logic [M-1:0] rz1,
                                     output logic [M-1:0] rx2, output logic [M-1:0] rz2);
    logic [M-1:0] ax, az, dx, dz, p1, p2, nax, naz, ndx, ndz;
    rx1 = x;
    rz1 = M'(1);
    rx2 = fsq(fsq(x)) ^ b;
    rz2 = fsq(x);
    for (int i = NB - 2; i >= 0; i--) begin
      if (k[i]) begin ax = rx1; az = rz1; dx = rx2; dz = rz2; end
      else      begin ax = rx2; az = rz2; dx = rx1; dz = rz1; end
      p1  = fmul(ax, dz);
      p2  = fmul(az, dx);
      naz = fsq(p1 ^ p2);
      nax = fmul(x, naz) ^ fmul(p1, p2);
      ndz = fmul(fsq(dx), fsq(dz));
      ndx = fsq(fsq(dx)) ^ fmul(b, fsq(fsq(dz)));
      if (k[i]) begin rx1 = nax; rz1 = naz; rx2 = ndx; rz2 = ndz; end
      else      begin rx2 = nax; rz2 = naz; rx1 = ndx; rz1 = ndz; end
    end
  endfunction

  // Cycle model of request acceptance and completion
  logic         m_busy = 1'b0;
  int           m_cnt = 0;
  logic         exp_done = 1'b0;
  logic [M-1:0] e_x1 = '0, e_z1 = '0, e_x2 = '0, e_z2 = '0;
  logic [M-1:0] i_x1 = '0, i_z1 = '0, i_x2 = '0, i_z2 = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_cnt = 0; exp_done = 1'b0;
      e_x1 = '0; e_z1 = '0; e_x2 = '0; e_z2 = '0;
    end else begin
      exp_done = 1'b0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == LAT) exp_done = 1'b1;
        if (m_cnt == LAT + 1) m_busy = 1'b0;
      end else if (start) begin
        m_busy = 1'b1;
        m_cnt  = 0;
        i_x1 = bx; i_z1 = M'(1); i_x2 = fsq(fsq(bx)) ^ cb; i_z2 = fsq(bx);
        ref_ladder(bx, cb, ks, e_x1, e_z1, e_x2, e_z2);
      end
    end
  end

  logic checking = 1'b0;

  always @(negedge clk) begin
    if (checking) begin
      chk("R7 R8 done timing", M'(done), M'(exp_done));
      if (m_busy && m_cnt == 1) begin
        chk("R1 init X1", x1, i_x1);
        chk("R1 init Z1", z1, i_z1);
        chk("R1 init X2", x2, i_x2);
        chk("R1 init Z2", z2, i_z2);
      end
      if (exp_done) begin
        chk({cur_tag, " final X1"}, x1, e_x1);
        chk({cur_tag, " final Z1"}, z1, e_z1);
        chk({cur_tag, " final X2"}, x2, e_x2);
        chk({cur_tag, " final Z2"}, z2, e_z2);
      end else if (!m_busy) begin
        chk("R9 hold X1", x1, e_x1);
        chk("R9 hold Z1", z1, e_z1);
        chk("R9 hold X2", x2, e_x2);
        chk("R9 hold Z2", z2, e_z2);
      end
    end
  end

  function automatic logic [M-1:0] rnd_elem();
    logic [M-1:0] r;
    for (int i = 0; i < M; i++) r[i] = 1'($urandom);
    return r;
  endfunction

  task automatic run_op(input logic [M-1:0] x, input logic [M-1:0] b, input logic [NB-1:0] k);
    @(negedge clk);
    bx = x; cb = b; ks = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R7 watchdog actual=still-running expected=finished");
    finish_run();
  end

  initial begin
    logic [NB-1:0] alt;
    for (int i = 0; i < NB; i++) alt[i] = 1'(i % 2);

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 reset X1", x1, '0);
    chk("R11 reset Z1", z1, '0);
    chk("R11 reset X2", x2, '0);
    chk("R11 reset Z2", z2, '0);
    chk("R11 reset done", M'(done), '0);
    rst_n = 1'b1;
    @(negedge clk);
    checking = 1'b1;

    // R3: all-ones scalar keeps roles fixed
    cur_tag = "R3 R4 R5 R6 all-ones";
    run_op(rnd_elem(), rnd_elem(), '1);

    // R3: alternating scalar swaps roles every bit
    cur_tag = "R3 R4 R5 R6 alternating";
    alt[NB-1] = 1'b1;
    run_op(rnd_elem(), rnd_elem(), alt);

    // Only the top bit set: every step takes the zero-bit path
    cur_tag = "R3 R4 R5 top-bit-only";
    run_op(rnd_elem(), rnd_elem(), {1'b1, {(NB-1){1'b0}}});

    // R2: top bit clear behaves as if set
    cur_tag = "R2 top bit ignored";
    alt[NB-1] = 1'b0;
    run_op(rnd_elem(), rnd_elem(), alt);

    // R10: request during a run is ignored
    cur_tag = "R10 mid-run request";
    @(negedge clk);
    bx = rnd_elem(); cb = rnd_elem(); ks = {1'b1, alt[NB-2:0] ^ {(NB-1){1'b1}}}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    bx = rnd_elem(); cb = rnd_elem(); ks = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!exp_done) @(negedge clk);

    // R10: request in the done cycle is ignored
    cur_tag = "R10 done-cycle request";
    bx = rnd_elem(); cb = rnd_elem(); ks = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);

    // Small operands and a random scalar
    cur_tag = "R4 R5 R6 small operands";
    run_op(M'(2), M'(1), {1'b1, NB'($urandom)} );
    cur_tag = "R3 R4 R5 R6 random";
    run_op(rnd_elem(), rnd_elem(), {1'b1, rnd_elem()});

    checking = 1'b0;
    finish_run();
  end

endmodule